// File: doc/BRIEF.md
# BCD Time-of-Day Register Bank

This block keeps calendar time in packed BCD and exposes it as eight byte-wide registers on a small address/data bus. A single-cycle pulse on the tick input advances the time by one second. Seconds carry into minutes, minutes into hours, and hours into the day. The day rollover advances the weekday and the date, the date rolls into the month, and the month rolls into the year. Leap-year February is handled.

Software loads one field at a time. Each load is checked for range, and a value outside its legal range leaves the field as it was. A halt flag kept in the top bit of the seconds register freezes the count. When the halt flag is cleared, counting resumes from the held value. The control register always reads back with fixed bits set and cleared. The day register carries a century flag next to the weekday.

Reads are registered: the data for an address presented with the read strobe appears on the data output after the next clock edge and stays there until the next read.

Top module: `tod_bank`

## Requirements
- R1: After reset the registers read: offset 0 = 0x90, seconds/minutes/hours = 0x00, day = 0x01, date = 0x01, month = 0x01, year = 0x00, and the halt flag is clear.
- R2: A write to offset 0 stores the byte with bits 7 and 5 cleared, and then with bits 7 and 4 set. Writing 0xFF reads back 0xDF, writing 0x00 reads back 0x90, and writing 0x25 reads back 0x95.
- R3: A write to offset 1 always stores bit 7 as the halt flag. Bits 6:0 are loaded as seconds only when both BCD digits are 0–9 and the value is 00–59. A read of offset 1 returns the halt flag in bit 7 and the seconds in bits 6:0.
- R4: A write to offset 2 loads minutes from bits 6:0 only if they form legal BCD 00–59. A write to offset 3 loads hours from bits 5:0 only if they form legal BCD 00–23. Any other value leaves the field unchanged.
- R5: A write to offset 4 stores bit 6 as the century flag and bits 2:0 as the weekday. The other bits are dropped, and a read returns the century flag in bit 6 ORed with the weekday in bits 2:0.
- R6: A write to offset 5 loads the date from bits 5:0 if the digits are legal BCD and the value is nonzero. A write to offset 6 loads the month from bits 4:0 if the value is 01–12. A write to offset 7 loads the year from the full byte if it is 00–99. Otherwise the field is unchanged.
- R7: While the halt flag is set, ticks change nothing. After the flag is cleared, counting continues from the held time.
- R8: Each tick while running adds one second. Seconds wrap 59→00 with a carry into minutes, minutes wrap 59→00 with a carry into hours, and hours wrap 23→00.
- R9: An hour wrap advances the weekday, with 7 going to 1. It also advances the date, which returns to 01 once it is at or past the month's last day. Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when the year value is divisible by four (00 included) and 28 days otherwise. All other months have 31 days.
- R10: A date wrap advances the month, and month 12 wraps to 01 with a carry into the year. Year 99 wraps to 00. The century flag is not changed by counting.
- R11: A write and a tick in the same cycle both take effect. The written field takes the written value, and all other fields advance as the tick demands.
- R12: Read data appears one clock edge after the read strobe and holds while no read is strobed, even as the time advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| tick | input | 1 | One-second advance pulse |
| rdata | output | 8 | Registered read data |

## Verification
A write or tick presented in one cycle changes the time state at that cycle's rising edge. A read strobed in a later cycle therefore sees the result, and its data appears after the following rising edge. The driver pushes each expected byte into a queue at the moment it raises the read strobe. The monitor pops and compares on the falling edge after the edge that registered the data, so every comparison is made half a cycle after the value settles. The hold check for R12 samples the output directly after ticks with no read strobe.

// File: rtl/tod_pkg.sv
package tod_pkg;
   localparam int TOD_NREGS = 8;
   localparam int TOD_AW    = $clog2(TOD_NREGS);

   typedef enum logic [TOD_AW-1:0] {
      OFS_CTRL = 3'd0, OFS_SEC = 3'd1, OFS_MIN = 3'd2, OFS_HOUR = 3'd3,
      OFS_DAY  = 3'd4, OFS_DATE = 3'd5, OFS_MON = 3'd6, OFS_YEAR = 3'd7
   } tod_ofs_e;

   typedef struct packed {
      logic       halt;
      logic [7:0] sec;
      logic [7:0] min;
      logic [7:0] hour;
      logic       cent;
      logic [2:0] wday;
      logic [7:0] date;
      logic [7:0] mon;
      logic [7:0] year;
   } tod_t;

   typedef struct packed {
      logic sec;
      logic halt;
      logic min;
      logic hour;
      logic day;
      logic date;
      logic mon;
      logic year;
   } tod_load_t;

   function automatic logic [7:0] bcd_val(input logic [7:0] v);
      return 8'(v[7:4]) * 8'd10 + 8'(v[3:0]);
   endfunction

   function automatic logic bcd_in_range(input logic [7:0] v,
                                         input logic [7:0] lo,
                                         input logic [7:0] hi);
      logic [7:0] b;
      b = bcd_val(v);
      return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9) && (b >= lo) && (b <= hi);
   endfunction

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
   endfunction

   function automatic logic [7:0] month_len(input logic [7:0] mon,
                                            input logic [7:0] year);
      logic [7:0] y;
      y = bcd_val(year);
      case (mon)
         8'h02:                      return (y[1:0] == 2'd0) ? 8'd29 : 8'd28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'd30;
         default:                    return 8'd31;
      endcase
   endfunction
endpackage

// File: rtl/tod_wdecode.sv
module tod_wdecode
   import tod_pkg::*;
(
   input  logic              wr_en,
   input  logic [TOD_AW-1:0] addr,
   input  logic [7:0]        wdata,
   output logic              ld_ctrl,
   output tod_load_t         ld
);
   logic [7:0] sec_f, hour_f, date_f, mon_f;

   assign sec_f  = {1'b0, wdata[6:0]};
   assign hour_f = {2'b0, wdata[5:0]};
   assign date_f = {2'b0, wdata[5:0]};
   assign mon_f  = {3'b0, wdata[4:0]};

   always_comb begin
      ld      = '0;
      ld_ctrl = 1'b0;
      if (wr_en) begin
         case (tod_ofs_e'(addr))
            OFS_CTRL: ld_ctrl = 1'b1;
            OFS_SEC: begin
               ld.halt = 1'b1;
               ld.sec  = bcd_in_range(sec_f, 8'd0, 8'd59);
            end
            OFS_MIN:  ld.min  = bcd_in_range(sec_f, 8'd0, 8'd59);
            OFS_HOUR: ld.hour = bcd_in_range(hour_f, 8'd0, 8'd23);
            OFS_DAY:  ld.day  = 1'b1;
            OFS_DATE: ld.date = bcd_in_range(date_f, 8'd1, 8'd39);
            OFS_MON:  ld.mon  = bcd_in_range(mon_f, 8'd1, 8'd12);
            OFS_YEAR: ld.year = bcd_in_range(wdata, 8'd0, 8'd99);
            default:  ;
         endcase
      end
   end
endmodule

// File: rtl/tod_calendar.sv
module tod_calendar
   import tod_pkg::*;
#(
   parameter logic [2:0] RST_WDAY = 3'd1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  tod_load_t  ld,
   input  logic [7:0] wdata,
   output tod_t       cur
);
   tod_t nx;
   logic ld_any;

   assign ld_any = |ld;

   always_comb begin
      nx = cur;
      if (tick && !cur.halt) begin
         if (cur.sec == 8'h59) begin
            nx.sec = 8'h00;
            if (cur.min == 8'h59) begin
               nx.min = 8'h00;
               if (cur.hour == 8'h23) begin
                  nx.hour = 8'h00;
                  nx.wday = (cur.wday == 3'd7) ? 3'd1 : cur.wday + 3'd1;
                  if (bcd_val(cur.date) >= month_len(cur.mon, cur.year)) begin
                     nx.date = 8'h01;
                     if (cur.mon == 8'h12) begin
                        nx.mon  = 8'h01;
                        nx.year = (cur.year == 8'h99) ? 8'h00 : bcd_inc(cur.year);
                     end else begin
                        nx.mon = bcd_inc(cur.mon);
                     end
                  end else begin
                     nx.date = bcd_inc(cur.date);
                  end
               end else begin
                  nx.hour = bcd_inc(cur.hour);
               end
            end else begin
               nx.min = bcd_inc(cur.min);
            end
         end else begin
            nx.sec = bcd_inc(cur.sec);
         end
      end
      if (ld.halt) nx.halt = wdata[7];
      if (ld.sec)  nx.sec  = {1'b0, wdata[6:0]};
      if (ld.min)  nx.min  = {1'b0, wdata[6:0]};
      if (ld.hour) nx.hour = {2'b0, wdata[5:0]};
      if (ld.day) begin
         nx.cent = wdata[6];
         nx.wday = wdata[2:0];
      end
      if (ld.date) nx.date = {2'b0, wdata[5:0]};
      if (ld.mon)  nx.mon  = {3'b0, wdata[4:0]};
      if (ld.year) nx.year = wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur      <= '0;
         cur.wday <= RST_WDAY;
         cur.date <= 8'h01;
         cur.mon  <= 8'h01;
      end else begin
         cur <= nx;
      end
   end

   // R7: a halted counter with no load holds every field
   a_r7_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (cur.halt && !ld_any) |=> $stable(cur));

   // R8: seconds at 59 with a running tick wrap and move minutes
   a_r8_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cur.halt && cur.sec == 8'h59 && !ld_any)
      |=> (cur.sec == 8'h00 && cur.min != $past(cur.min)));

   // R4: seconds field never leaves legal BCD 00-59
   a_r4_sec_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (cur.sec <= 8'h59) && (cur.sec[3:0] <= 4'd9));

   // R6: month field stays within 01-12
   a_r6_mon_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (cur.mon >= 8'h01) && (cur.mon <= 8'h12));

   // R11: without tick or load the state is unchanged
   a_r11_idle_still: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !ld_any) |=> $stable(cur));
endmodule

// File: rtl/tod_readmux.sv
module tod_readmux
   import tod_pkg::*;
#(
   parameter bit REG_READ = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [TOD_AW-1:0] addr,
   input  tod_t              cur,
   input  logic [7:0]        ctrl,
   output logic [7:0]        rdata
);
   logic [7:0] sel;

   always_comb begin
      case (tod_ofs_e'(addr))
         OFS_CTRL: sel = ctrl;
         OFS_SEC:  sel = {cur.halt, cur.sec[6:0]};
         OFS_MIN:  sel = cur.min;
         OFS_HOUR: sel = cur.hour;
         OFS_DAY:  sel = {1'b0, cur.cent, 3'b000, cur.wday};
         OFS_DATE: sel = cur.date;
         OFS_MON:  sel = cur.mon;
         OFS_YEAR: sel = cur.year;
         default:  sel = 8'hFF;
      endcase
   end

   generate
      if (REG_READ) begin : g_reg
         logic [7:0] rdata_q;
         always_ff @(posedge clk) begin
            if (!rst_n)     rdata_q <= 8'h00;
            else if (rd_en) rdata_q <= sel;
         end
         assign rdata = rdata_q;

         // R12: output holds between read strobes
         a_r12_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_en |=> $stable(rdata));
      end else begin : g_comb
         assign rdata = sel;
      end
   endgenerate
endmodule

// File: rtl/tod_bank.sv
module tod_bank
   import tod_pkg::*;
#(
   parameter int         DATA_W   = 8,
   parameter bit         REG_READ = 1'b1,
   parameter logic [7:0] CTRL_CLR = 8'hA0,
   parameter logic [7:0] CTRL_SET = 8'h90,
   parameter int         RST_WDAY = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TOD_AW-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_en,
   input  logic              tick,
   output logic [DATA_W-1:0] rdata
);
   localparam logic [7:0] CTRL_RST  = CTRL_SET;
   localparam logic [7:0] CTRL_ZERO = CTRL_CLR & ~CTRL_SET;

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("tod_bank: DATA_W must be 8");
      end
      if (RST_WDAY < 1 || RST_WDAY > 7) begin : g_bad_wday
         $error("tod_bank: RST_WDAY must be 1..7");
      end
   endgenerate

   logic       ld_ctrl;
   tod_load_t  ld;
   tod_t       cur;
   logic [7:0] ctrl_q;

   tod_wdecode u_dec (
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .ld_ctrl (ld_ctrl),
      .ld      (ld)
   );

   tod_calendar #(.RST_WDAY(3'(RST_WDAY))) u_cal (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .ld    (ld),
      .wdata (wdata),
      .cur   (cur)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       ctrl_q <= CTRL_RST;
      else if (ld_ctrl) ctrl_q <= (wdata & ~CTRL_CLR) | CTRL_SET;
   end

   tod_readmux #(.REG_READ(REG_READ)) u_rd (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_en (rd_en),
      .addr  (addr),
      .cur   (cur),
      .ctrl  (ctrl_q),
      .rdata (rdata)
   );

   // R2: forced-one bits always set, forced-zero bits always clear
   a_r2_ctrl_forced: assert property (@(posedge clk) disable iff (!rst_n)
      ((ctrl_q & CTRL_SET) == CTRL_SET) && ((ctrl_q & CTRL_ZERO) == 8'h00));
endmodule

// File: tb/sim_tod_bank.sv
module sim_tod_bank;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] addr = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wdata = '0;
   logic       rd_en = 1'b0;
   logic       tick = 1'b0;
   logic [7:0] rdata;

   always #5 clk = ~clk;

   tod_bank u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
      .rd_en(rd_en), .tick(tick), .rdata(rdata)
   );

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic       rd_seen = 1'b0;

   always @(posedge clk) rd_seen <= rd_en;

   // monitor: compare one registered read per strobe
   always @(negedge clk) begin
      if (rd_seen === 1'b1) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL unexpected read data %02h", rdata);
         end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (rdata !== e) begin
               errors++;
               $display("FAIL %s actual %02h expected %02h", t, rdata, e);
            end
         end
      end
   end

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic wr_tick(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1'b1; tick = 1'b1;
      @(negedge clk); wr_en = 1'b0; tick = 1'b0;
   endtask

   task automatic tk(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
      @(negedge clk); addr = a; rd_en = 1'b1;
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic set_end_of_day();
      wr(3'd3, 8'h23); wr(3'd2, 8'h59); wr(3'd1, 8'h59);
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      rd(3'd0, 8'h90, "R1 ctrl"); rd(3'd1, 8'h00, "R1 sec");
      rd(3'd2, 8'h00, "R1 min");  rd(3'd3, 8'h00, "R1 hour");
      rd(3'd4, 8'h01, "R1 day");  rd(3'd5, 8'h01, "R1 date");
      rd(3'd6, 8'h01, "R1 month"); rd(3'd7, 8'h00, "R1 year");

      // R2 control forcing
      wr(3'd0, 8'hFF); rd(3'd0, 8'hDF, "R2 ctrl FF");
      wr(3'd0, 8'h00); rd(3'd0, 8'h90, "R2 ctrl 00");
      wr(3'd0, 8'h25); rd(3'd0, 8'h95, "R2 ctrl 25");

      // R8 seconds count and carry
      wr(3'd1, 8'h58); tk(1); rd(3'd1, 8'h59, "R8 sec 59");
      tk(1); rd(3'd1, 8'h00, "R8 sec wrap"); rd(3'd2, 8'h01, "R8 min carry");

      // R3 seconds validation and halt flag
      wr(3'd1, 8'h42); rd(3'd1, 8'h42, "R3 sec load");
      wr(3'd1, 8'h5A); rd(3'd1, 8'h42, "R3 bad digit");
      wr(3'd1, 8'h60); rd(3'd1, 8'h42, "R3 over 59");
      wr(3'd1, 8'hFF); rd(3'd1, 8'hC2, "R3 halt set");
      // R7 halt freezes, then resumes
      tk(3); rd(3'd1, 8'hC2, "R7 frozen");
      wr(3'd1, 8'h7F); rd(3'd1, 8'h42, "R7 halt clear");
      tk(1); rd(3'd1, 8'h43, "R7 resume");

      // R4 minutes and hours validation
      wr(3'd2, 8'h60); rd(3'd2, 8'h01, "R4 min over");
      wr(3'd2, 8'h3F); rd(3'd2, 8'h01, "R4 min digit");
      wr(3'd2, 8'hD9); rd(3'd2, 8'h59, "R4 min masked");
      wr(3'd3, 8'h24); rd(3'd3, 8'h00, "R4 hour over");
      wr(3'd3, 8'hE3); rd(3'd3, 8'h23, "R4 hour masked");

      // R5 day register, R9 day rollover
      wr(3'd1, 8'h59);
      wr(3'd4, 8'hC5); rd(3'd4, 8'h45, "R5 day store");
      tk(1);
      rd(3'd1, 8'h00, "R8 sec at day"); rd(3'd2, 8'h00, "R8 min at day");
      rd(3'd3, 8'h00, "R8 hour wrap");  rd(3'd4, 8'h46, "R9 wday inc");
      rd(3'd5, 8'h02, "R9 date inc");   rd(3'd6, 8'h01, "R9 month same");
      wr(3'd4, 8'h07); rd(3'd4, 8'h07, "R5 wday 7");
      set_end_of_day(); tk(1);
      rd(3'd4, 8'h01, "R9 wday wrap"); rd(3'd5, 8'h03, "R9 date 3");

      // R6 date, month, year validation
      wr(3'd5, 8'h00); rd(3'd5, 8'h03, "R6 date zero");
      wr(3'd5, 8'hC0); rd(3'd5, 8'h03, "R6 date zero masked");
      wr(3'd5, 8'h1A); rd(3'd5, 8'h03, "R6 date digit");
      wr(3'd5, 8'h31); rd(3'd5, 8'h31, "R6 date load");
      wr(3'd6, 8'h13); wr(3'd6, 8'h00); rd(3'd6, 8'h01, "R6 month bad");
      wr(3'd6, 8'h12); rd(3'd6, 8'h12, "R6 month load");
      wr(3'd7, 8'h9A); wr(3'd7, 8'hA0); rd(3'd7, 8'h00, "R6 year bad");
      wr(3'd7, 8'h99); rd(3'd7, 8'h99, "R6 year load");

      // R10 year-end rollover, century kept
      wr(3'd4, 8'h47);
      set_end_of_day(); tk(1);
      rd(3'd7, 8'h00, "R10 year wrap"); rd(3'd6, 8'h01, "R10 month wrap");
      rd(3'd5, 8'h01, "R10 date wrap"); rd(3'd4, 8'h41, "R10 century kept");

      // R9 month lengths and leap years
      wr(3'd7, 8'h24); wr(3'd6, 8'h02); wr(3'd5, 8'h28);
      set_end_of_day(); tk(1); rd(3'd5, 8'h29, "R9 leap feb 29");
      set_end_of_day(); tk(1); rd(3'd5, 8'h01, "R9 leap date");
      rd(3'd6, 8'h03, "R9 leap march");
      wr(3'd7, 8'h00); wr(3'd6, 8'h02); wr(3'd5, 8'h28);
      set_end_of_day(); tk(1); rd(3'd5, 8'h29, "R9 year 00 leap");
      wr(3'd7, 8'h23); wr(3'd6, 8'h02); wr(3'd5, 8'h28);
      set_end_of_day(); tk(1); rd(3'd5, 8'h01, "R9 nonleap date");
      rd(3'd6, 8'h03, "R9 nonleap march");
      wr(3'd6, 8'h04); wr(3'd5, 8'h30);
      set_end_of_day(); tk(1); rd(3'd5, 8'h01, "R9 april end");
      rd(3'd6, 8'h05, "R9 may");
      wr(3'd6, 8'h01); wr(3'd5, 8'h30);
      set_end_of_day(); tk(1); rd(3'd5, 8'h31, "R9 january 31");

      // R11 write together with tick
      wr(3'd1, 8'h10);
      wr_tick(3'd2, 8'h05);
      rd(3'd1, 8'h11, "R11 sec advanced"); rd(3'd2, 8'h05, "R11 min written");
      wr_tick(3'd1, 8'h30);
      rd(3'd1, 8'h30, "R11 sec write wins"); rd(3'd2, 8'h05, "R11 min kept");

      // R12 output holds without read strobe
      rd(3'd1, 8'h30, "R12 read");
      tk(2);
      @(negedge clk);
      checks++;
      if (rdata !== 8'h30) begin
         errors++;
         $display("FAIL R12 hold actual %02h expected %02h", rdata, 8'h30);
      end
      rd(3'd1, 8'h32, "R12 fresh read");

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard left %0d expected items", exp_q.size());
      end
      finish_run();
   end
endmodule